// File: doc/BRIEF.md
# Unstoppable Watchdog Timer with Edge-Qualified Reset

This block is a watchdog that never stops counting. An 8-bit down-counter is loaded from a preset byte. It decrements once per time unit, and the unit is either one second or one minute. The seconds come from an external one-second tick strobe. In minute mode a prescaler divides that strobe by a parameterised count, 60 by default. The only way to keep the system alive is to write the preset register: that write reloads the counter and restarts the prescaler. When the counter runs out, it reloads from the preset and keeps counting. Each expiry also sets an event flag in a status register, and software clears that flag by writing a one to it.

Software cannot stop the countdown. It can only mask the reset output through an enable bit in the output-enable register. A reset pulse of a configurable number of clock cycles is issued only when the event flag goes from 0 to 1 while the output is enabled. Enabling the output after the flag is already set gives no reset. Neither does a further expiry while the flag is still set.

A simple synchronous register port is assumed. A write happens on any clock edge where `wr_en` is high. The read data is a combinational function of `rd_addr`.

Top module: `wdog_core`

## Requirements
- R1: After reset the registers read back as follows: preset 0xFF, control 0x01 (second units), output-enable 0x00, status 0x00. `sys_reset_o` is low.
- R2: Preset (address 0x58B), control (0x58C) and output-enable (0x58E) each store and read back the full byte written, from the cycle after the write. Status (0x009) reads the event flag in bit 0 and zeros elsewhere. Any other address reads 0x00.
- R3: When control bit 0 is 1, every tick is one unit. After a preset write of N, the Nth following tick expires the counter. The event flag reads 1 in the cycle after that tick.
- R4: When control bit 0 is 0, one unit is 60 ticks. A control write that changes bit 0 restarts the prescaler from zero. A control write that keeps bit 0 unchanged does not restart it.
- R5: A preset write reloads the counter with the written value and restarts the prescaler. Writing it more often than the timeout prevents any expiry.
- R6: On expiry the counter reloads from the stored preset and keeps counting, so expiries repeat every preset-many units.
- R7: Writing 1 to status bit 0 clears the event flag. Writing 0 there leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R8: A 0-to-1 change of the event flag while output-enable bit 1 is set drives `sys_reset_o` high. It goes high in the same cycle the flag first reads 1 and stays high for RST_LEN (default 8) cycles.
- R9: With output-enable bit 1 clear, expiries still set the event flag and the counter still runs, but `sys_reset_o` stays low.
- R10: Setting output-enable bit 1 while the flag is already 1 gives no reset. An expiry while the flag is still 1 gives no reset.
- R11: A preset of 0 behaves like a preset of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe marking each elapsed second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 12 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| sys_reset_o | output | 1 | System reset pulse |

## Verification
A register write shows in the read data one cycle after the clock edge that takes it. An expiring tick sets the event flag at the edge that samples the tick, and `sys_reset_o` rises at that same edge and then holds for RST_LEN cycles. The bench keeps a behavioural model that advances on the same edge as the design. It drives inputs and compares both outputs at the falling edge, so every result is checked in the exact cycle it is due. The read address rotates through all the registers with status every other cycle, so the flag is observed almost continuously.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int BYTE_W = 8;
    // bit positions that software relies on
    localparam int TB_BIT  = 0;   // control: 1 = second units, 0 = minute units
    localparam int OEN_BIT = 1;   // output-enable: gates the reset
    localparam int EVT_BIT = 0;   // status: expiry event, write-one-to-clear

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic preset;
        logic ctrl;
        logic oen;
        logic stat;
    } wr_sel_t;
endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] PRESET_ADDR = 12'h58B,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 12'h58C,
    parameter logic [ADDR_W-1:0] OEN_ADDR    = 12'h58E,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = 12'h009
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  byte_t             wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              evt,
    output byte_t             rd_data,
    output byte_t             preset,
    output logic              sec_mode,
    output logic              oen,
    output wr_sel_t           sel,
    output logic              base_change
);
    typedef struct packed {
        byte_t preset;
        byte_t ctrl;
        byte_t oen;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        sel.preset = wr_en && (wr_addr == PRESET_ADDR);
        sel.ctrl   = wr_en && (wr_addr == CTRL_ADDR);
        sel.oen    = wr_en && (wr_addr == OEN_ADDR);
        sel.stat   = wr_en && (wr_addr == STAT_ADDR);
        base_change = sel.ctrl && (wr_data[TB_BIT] != r_q.ctrl[TB_BIT]);

        r_d = r_q;
        if (sel.preset) r_d.preset = wr_data;
        if (sel.ctrl)   r_d.ctrl   = wr_data;
        if (sel.oen)    r_d.oen    = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.preset <= 8'hFF;
            r_q.ctrl   <= 8'h01;
            r_q.oen    <= 8'h00;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == PRESET_ADDR)     rd_data = r_q.preset;
        else if (rd_addr == CTRL_ADDR)  rd_data = r_q.ctrl;
        else if (rd_addr == OEN_ADDR)   rd_data = r_q.oen;
        else if (rd_addr == STAT_ADDR)  rd_data[EVT_BIT] = evt;
    end

    assign preset   = r_q.preset;
    assign sec_mode = r_q.ctrl[TB_BIT];
    assign oen      = r_q.oen[OEN_BIT];
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int TICKS_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sec_mode,
    input  logic restart,
    output logic unit,
    output logic [$clog2(TICKS_PER_MIN)-1:0] presc
);
    localparam int PW = $clog2(TICKS_PER_MIN);
    localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MIN - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } ps_t;

    ps_t p_d, p_q;

    always_comb begin
        p_d  = p_q;
        unit = 1'b0;
        if (sec_mode) begin
            p_d.cnt = '0;
            unit    = tick;
        end else if (tick) begin
            if (p_q.cnt == LAST) begin
                p_d.cnt = '0;
                unit    = 1'b1;
            end else begin
                p_d.cnt = p_q.cnt + 1'b1;
            end
        end
        if (restart) p_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign presc = p_q.cnt;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] preset,
    output logic             expire,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ct_t;

    ct_t c_d, c_q;

    always_comb begin
        c_d    = c_q;
        expire = 1'b0;
        if (load) begin
            c_d.cnt = load_val;
        end else if (unit) begin
            // a count of 0 or 1 runs out on this unit
            if (c_q.cnt <= CNT_W'(1)) begin
                expire  = 1'b1;
                c_d.cnt = preset;
            end else begin
                c_d.cnt = c_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q.cnt <= '1;
        else        c_q <= c_d;
    end

    assign cnt = c_q.cnt;
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
    parameter int RST_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr,
    input  logic oen,
    output logic evt,
    output logic sys_reset_o
);
    localparam int LW = $clog2(RST_LEN + 1);

    typedef struct packed {
        logic          evt;
        logic [LW-1:0] len;
    } rp_t;

    rp_t s_d, s_q;
    logic rise;

    always_comb begin
        s_d  = s_q;
        rise = expire && !s_q.evt;
        // set dominates clear
        s_d.evt = expire || (s_q.evt && !clr);
        if (rise && oen)
            s_d.len = LW'(RST_LEN);
        else if (s_q.len != '0)
            s_d.len = s_q.len - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign evt         = s_q.evt;
    assign sys_reset_o = (s_q.len != '0);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int ADDR_W        = 12,
    parameter int CNT_W         = 8,
    parameter int TICKS_PER_MIN = 60,
    parameter int RST_LEN       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              sys_reset_o
);
    localparam int PW = $clog2(TICKS_PER_MIN);

    byte_t            preset;
    logic             sec_mode;
    logic             oen;
    wr_sel_t          sel;
    logic             base_change;
    logic             unit;
    logic [PW-1:0]    presc;
    logic             expire;
    logic [CNT_W-1:0] cnt;
    logic             evt;
    logic             clr;
    logic             preset_wr;
    logic             presc_restart;

    assign preset_wr     = sel.preset;
    assign presc_restart = sel.preset || base_change;
    assign clr           = sel.stat && wr_data[EVT_BIT];

    wdog_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .evt(evt), .rd_data(rd_data),
        .preset(preset), .sec_mode(sec_mode), .oen(oen),
        .sel(sel), .base_change(base_change)
    );

    wdog_prescaler #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .sec_mode(sec_mode),
        .restart(presc_restart), .unit(unit), .presc(presc)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .unit(unit), .load(preset_wr),
        .load_val(CNT_W'(wr_data)), .preset(CNT_W'(preset)),
        .expire(expire), .cnt(cnt)
    );

    wdog_rst_pulse #(.RST_LEN(RST_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .expire(expire), .clr(clr), .oen(oen),
        .evt(evt), .sys_reset_o(sys_reset_o)
    );
endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sys_reset_o,
    input logic             evt,
    input logic             oen,
    input logic             expire,
    input logic             clr,
    input logic             preset_wr,
    input logic [7:0]       wr_data,
    input logic [7:0]       preset,
    input logic [CNT_W-1:0] cnt
);
    assert_flag_from_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt) |-> $past(expire));

    assert_preset_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(preset_wr) |-> cnt == CNT_W'($past(wr_data)));

    assert_reload_after_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(expire) && !$past(preset_wr)) |-> cnt == CNT_W'($past(preset)));

    assert_clear_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr) && !$past(expire)) |-> !evt);

    assert_reset_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_reset_o) |-> $rose(evt));

    assert_reset_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_reset_o) |-> $past(oen));
endmodule

bind wdog_core wdog_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sys_reset_o(sys_reset_o), .evt(evt),
    .oen(oen), .expire(expire), .clr(clr), .preset_wr(preset_wr),
    .wr_data(wr_data), .preset(preset), .cnt(cnt)
);

// File: tb/wdog_core_test.sv
module wdog_core_test;
    localparam int TPM  = 60;
    localparam int RLEN = 8;
    localparam logic [11:0] A_PRE = 12'h58B;
    localparam logic [11:0] A_CTL = 12'h58C;
    localparam logic [11:0] A_OEN = 12'h58E;
    localparam logic [11:0] A_STS = 12'h009;
    localparam logic [11:0] A_NONE = 12'h123;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [11:0] rd_addr = A_STS;
    logic [7:0]  rd_data;
    logic        sys_reset_o;

    always #2 clk = ~clk;

    wdog_core uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .sys_reset_o(sys_reset_o)
    );

    // behavioural reference
    int m_pre = 255, m_ctl = 1, m_oen = 0, m_evt = 0, m_cnt = 255, m_ps = 0, m_rst = 0;
    int vectors = 0, miscompares = 0;
    string cur_req = "R1";
    int ph = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 255; m_ctl = 1; m_oen = 0; m_evt = 0; m_cnt = 255; m_ps = 0; m_rst = 0;
        end else begin
            bit secm, unit, expire, wp, wc, wo, ws, restart;
            secm = m_ctl[0];
            unit = sec_tick && (secm || m_ps == TPM - 1);
            wp = wr_en && wr_addr == A_PRE;
            wc = wr_en && wr_addr == A_CTL;
            wo = wr_en && wr_addr == A_OEN;
            ws = wr_en && wr_addr == A_STS;
            restart = wp || (wc && (wr_data[0] != m_ctl[0]));
            expire = 0;
            if (wp) m_cnt = wr_data;
            else if (unit) begin
                if (m_cnt <= 1) begin expire = 1; m_cnt = m_pre; end
                else m_cnt = m_cnt - 1;
            end
            if (restart || secm) m_ps = 0;
            else if (sec_tick) m_ps = (m_ps == TPM - 1) ? 0 : m_ps + 1;
            if (expire && m_evt == 0 && m_oen[1]) m_rst = RLEN;
            else if (m_rst > 0) m_rst = m_rst - 1;
            if (expire) m_evt = 1;
            else if (ws && wr_data[0]) m_evt = 0;
            if (wp) m_pre = wr_data;
            if (wc) m_ctl = wr_data;
            if (wo) m_oen = wr_data;
        end
    end

    function automatic logic [7:0] exp_rd(logic [11:0] a);
        if (a == A_PRE) return 8'(m_pre);
        if (a == A_CTL) return 8'(m_ctl);
        if (a == A_OEN) return 8'(m_oen);
        if (a == A_STS) return 8'(m_evt);
        return 8'h00;
    endfunction

    task automatic compare();
        logic [7:0] e;
        e = exp_rd(rd_addr);
        vectors++;
        if (rd_data !== e || sys_reset_o !== (m_rst != 0)) begin
            miscompares++;
            $display("FAIL %s t=%0t addr=%h rd_data=%h expected %h sys_reset_o=%b expected %b",
                     cur_req, $time, rd_addr, rd_data, e, sys_reset_o, (m_rst != 0));
        end
    endtask

    task automatic step(input logic t, input logic we, input logic [11:0] a, input logic [7:0] d);
        logic [11:0] seq [8];
        seq = '{A_STS, A_PRE, A_STS, A_CTL, A_STS, A_OEN, A_STS, A_NONE};
        @(negedge clk);
        compare();
        sec_tick = t; wr_en = we; wr_addr = a; wr_data = d;
        rd_addr = seq[ph];
        ph = (ph + 1) % 8;
    endtask

    task automatic idle(input int n, input int tick_every);
        for (int i = 0; i < n; i++)
            step((tick_every > 0) && (i % tick_every == 0), 1'b0, '0, '0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        step(1'b0, 1'b1, a, d);
    endtask

    initial begin
        #(4 * 200000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R1: reset values
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(8, 0);
        // R2: full-byte readback, unmapped reads zero
        cur_req = "R2";
        wr(A_CTL, 8'hA5); wr(A_OEN, 8'h5C); wr(A_PRE, 8'h33);
        idle(10, 0);
        wr(A_CTL, 8'h01); wr(A_OEN, 8'h00);
        // R3 / R6 / R9: second units, repeated expiry with output masked
        cur_req = "R3";
        wr(A_PRE, 8'd5);
        idle(18, 1);
        cur_req = "R6";
        idle(30, 3);
        // R9 is covered by the run above: flag set, no reset
        cur_req = "R9";
        idle(4, 0);
        // R7: write 0 does not clear, write 1 clears, expiry beats clear
        cur_req = "R7";
        wr(A_STS, 8'hFE); idle(4, 0);
        wr(A_STS, 8'h01); idle(4, 0);
        wr(A_PRE, 8'd1);
        step(1'b1, 1'b1, A_STS, 8'h01);
        step(1'b1, 1'b1, A_STS, 8'h01);
        idle(4, 0);
        // R8: qualified reset pulse
        cur_req = "R8";
        wr(A_STS, 8'h01); wr(A_OEN, 8'h02); wr(A_PRE, 8'd3);
        idle(20, 1);
        // R10: second expiry while flag set gives no reset
        cur_req = "R10";
        idle(20, 1);
        wr(A_OEN, 8'h00); wr(A_STS, 8'h01); wr(A_PRE, 8'd2);
        idle(4, 1);
        wr(A_OEN, 8'h02);
        idle(6, 0);
        // R5: keep-alive by preset writes
        cur_req = "R5";
        wr(A_STS, 8'h01); wr(A_PRE, 8'd4);
        for (int k = 0; k < 8; k++) begin
            idle(3, 1);
            step(1'b1, 1'b1, A_PRE, 8'd4);
        end
        idle(10, 1);
        // R4: minute units, restart on time-base change only
        cur_req = "R4";
        wr(A_STS, 8'h01); wr(A_CTL, 8'h00); wr(A_PRE, 8'd2);
        idle(30, 1);
        wr(A_CTL, 8'h00);
        idle(20, 1);
        wr(A_CTL, 8'h01); wr(A_CTL, 8'h00);
        idle(135, 1);
        wr(A_STS, 8'h01);
        idle(70, 2);
        // R11: preset 0 acts as 1
        cur_req = "R11";
        wr(A_CTL, 8'h01); wr(A_STS, 8'h01); wr(A_PRE, 8'd0);
        idle(12, 2);
        @(negedge clk);
        compare();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule